// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers interrupt requests from a set of devices (eight by default) and presents a single combined request line to the processor. It picks one winner among the pending requests by fixed polling order, where the lowest-numbered device is served first. A request only counts when the device's fixed priority is strictly above the processor's current priority level. When the processor acknowledges, the block returns a vector code that identifies the winner and sends a one-cycle acknowledge pulse back to that device so that the device can withdraw its request.

The current priority level is a writable field. Accepting an interrupt raises the level to the winner's priority and saves the old level on a small stack, four entries deep by default. A return strobe restores the saved level, so service routines can nest. A global enable bit gates the combined request line. A vector base register sets where the vector codes start.

Top module: `prio_vec_intc`

## Requirements
- R1: `cpu_irq` is high exactly when the enable bit is set, the stack is not full, and at least one device is eligible. It is a combinational function of the current inputs and state.
- R2: Among the eligible devices, the one with the lowest index wins.
- R3: Device i has priority `NUM_SRC - i` (8 down to 1 by default). It is eligible only when its request is high and that priority is strictly greater than `cur_level`.
- R4: A pulse on `cpu_inta` while `cpu_irq` is high is an accept. In the next cycle `vec_valid` is high for one cycle, `vec_out` equals base + 4 × winner index modulo 2^VEC_W, and `dev_ack` has only the winner's bit set, also for one cycle. A pulse on `cpu_inta` while `cpu_irq` is low produces no `vec_valid`, no `dev_ack` and no change of level.
- R5: An accept sets `cur_level` to the winner's priority from the next cycle on, and pushes the previous level onto the stack.
- R6: A pulse on `cpu_iret` restores the most recently pushed level. When the stack is empty, `cpu_iret` leaves `cur_level` unchanged.
- R7: Configuration writes take effect in the next cycle. With `cfg_addr`=0, bits [3:0] of `cfg_wdata` become `cur_level` and bit 7 becomes the enable bit. With `cfg_addr`=1, all of `cfg_wdata` becomes the vector base.
- R8: While the stack holds four saved levels, `cpu_irq` stays low whatever is pending. It can rise again after a pop.
- R9: Reset clears the enable bit, `cur_level`, the stack, `vec_valid` and `dev_ack`.
- R10: When an accept and `cpu_iret` occur in the same cycle, only the accept takes effect and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | NUM_SRC | Per-device request levels |
| dev_ack | output | NUM_SRC | One-cycle acknowledge to the winning device |
| cpu_irq | output | 1 | Combined request to the processor |
| cpu_inta | input | 1 | Acknowledge strobe from the processor |
| cpu_iret | input | 1 | Return-from-interrupt strobe |
| vec_out | output | VEC_W | Vector code of the accepted device |
| vec_valid | output | 1 | `vec_out` is valid this cycle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: level and enable, 1: vector base |
| cfg_wdata | input | VEC_W | Configuration write data |
| cur_level | output | LVL_W | Current processor priority level |

## Verification
The assertions check on every cycle that at most one acknowledge is active, that every accept is followed by a single vector and acknowledge and by the winner's level, that any winner really is requesting above the current level, and that nothing is pushed onto a full stack. A pop on an empty stack is checked the same way. Which device wins for each request pattern, the vector arithmetic including wrap-around, the restore order of nested levels, and the rule that an accept takes precedence over a simultaneous return are shown only by the bench. It sweeps every request pattern against every reachable level.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Fixed priority of a device: index 0 carries the top level.
  function automatic int unsigned src_level(input int unsigned idx, input int unsigned nsrc);
    return nsrc - idx;
  endfunction

  // Vector code for a device before truncation to the port width.
  function automatic int unsigned vec_for(input int unsigned base, input int unsigned idx,
                                          input int unsigned stride);
    return base + idx * stride;
  endfunction
endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [LVL_W-1:0]   cur_level,
  output logic [NUM_SRC-1:0] elig,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_level
);
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      elig[i] = req[i] &&
        (intc_pkg::src_level(int'(i), NUM_SRC) > int'(cur_level));
    end
  end

  // Scan from the far end so the lowest eligible index is left standing.
  always_comb begin
    win_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = IDX_W'(i);
    end
    win_valid = |elig;
    win_level = LVL_W'(intc_pkg::src_level(int'(win_idx), NUM_SRC));
  end
endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack #(
  parameter int LVL_W = 4,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_level,
  input  logic             pop,
  input  logic             wr_level,
  input  logic [LVL_W-1:0] wr_value,
  output logic [LVL_W-1:0] cur_level,
  output logic             full,
  output logic             empty
);
  logic [LVL_W-1:0] stk [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [LVL_W-1:0] top_lvl;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);

  always_comb begin
    top_lvl = '0;
    for (int g = 0; g < DEPTH; g++) begin
      if (int'(cnt) == g + 1) top_lvl = stk[g];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stk[g] <= '0;
      else if (push && int'(cnt) == g) stk[g] <= cur_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cur_level <= '0;
    end else if (push) begin
      cnt       <= cnt + 1'b1;
      cur_level <= push_level;
    end else if (pop && !empty) begin
      cnt       <= cnt - 1'b1;
      cur_level <= top_lvl;
    end else if (wr_level) begin
      cur_level <= wr_value;
    end
  end

  // R8: a push never lands on a full stack
  assert_push_not_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R6: popping an empty stack leaves the level alone
  assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !wr_level) |=> $stable(cur_level));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NUM_SRC    = 8,
  parameter int LVL_W      = 4,
  parameter int VEC_W      = 8,
  parameter int VEC_STRIDE = 4,
  parameter int STK_DEPTH  = 4,
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int EN_BIT    = VEC_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] dev_req,
  output logic [NUM_SRC-1:0] dev_ack,
  output logic               cpu_irq,
  input  logic               cpu_inta,
  input  logic               cpu_iret,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  input  logic               cfg_wr,
  input  logic               cfg_addr,
  input  logic [VEC_W-1:0]   cfg_wdata,
  output logic [LVL_W-1:0]   cur_level
);
  logic               en_q;
  logic [VEC_W-1:0]   base_q;
  logic [NUM_SRC-1:0] elig;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_level;
  logic               stk_full, stk_empty;
  logic               accept, pop_req, wr_ctl, wr_base;
  logic [NUM_SRC-1:0] ack_d;

  intc_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_pick (
    .req(dev_req), .cur_level(cur_level), .elig(elig),
    .win_valid(win_valid), .win_idx(win_idx), .win_level(win_level)
  );

  assign cpu_irq = en_q && win_valid && !stk_full;
  assign accept  = cpu_inta && cpu_irq;
  assign pop_req = cpu_iret && !accept;
  assign wr_ctl  = cfg_wr && !cfg_addr;
  assign wr_base = cfg_wr && cfg_addr;

  intc_lvl_stack #(.LVL_W(LVL_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_level(win_level),
    .pop(pop_req),
    .wr_level(wr_ctl), .wr_value(cfg_wdata[LVL_W-1:0]),
    .cur_level(cur_level), .full(stk_full), .empty(stk_empty)
  );

  always_comb begin
    ack_d = '0;
    if (accept) ack_d[win_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      base_q    <= '0;
      dev_ack   <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      if (wr_ctl)  en_q   <= cfg_wdata[EN_BIT];
      if (wr_base) base_q <= cfg_wdata;
      dev_ack   <= ack_d;
      vec_valid <= accept;
      if (accept)
        vec_out <= VEC_W'(intc_pkg::vec_for(int'(base_q), int'(win_idx), VEC_STRIDE));
    end
  end

  // R4: never more than one device acknowledged
  assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));
  // R4: an accept yields one vector and one acknowledge next cycle
  assert_accept_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (vec_valid && $countones(dev_ack) == 1));
  // R5: the level follows the winner that was accepted
  assert_level_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cur_level == $past(win_level)));
  // R3: a winner is really requesting above the current level
  assert_winner_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (dev_req[win_idx] && win_level > cur_level));
  // R1: the combined line implies some request is present
  assert_irq_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (|dev_req));
endmodule

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_req = '0;
  logic [7:0] dev_ack;
  logic       cpu_irq;
  logic       cpu_inta = 1'b0, cpu_iret = 1'b0;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic       cfg_wr = 1'b0, cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] cur_level;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prio_vec_intc u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ack(dev_ack),
    .cpu_irq(cpu_irq), .cpu_inta(cpu_inta), .cpu_iret(cpu_iret),
    .vec_out(vec_out), .vec_valid(vec_valid), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cur_level(cur_level)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int pick(input logic [7:0] p, input int lvl);
    for (int i = 0; i < 8; i++) if (p[i] && (8 - i) > lvl) return i;
    return -1;
  endfunction

  task automatic cfg(input bit a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  // Present pattern, check line, acknowledge, check vector, then return.
  task automatic run_pat(input logic [7:0] p, input int lvl, input int base);
    int w;
    w = pick(p, lvl);
    @(negedge clk); dev_req = p; #1;
    chk(cpu_irq == (w >= 0), "R1/R3 irq", cpu_irq, w >= 0);
    cpu_inta = 1;
    @(negedge clk); cpu_inta = 0; dev_req = '0;
    if (w >= 0) begin
      chk(vec_valid == 1 && vec_out == 8'((base + 4 * w) % 256), "R4/R2 vector",
          vec_out, (base + 4 * w) % 256);
      chk(dev_ack == 8'(1 << w), "R4 ack", dev_ack, 1 << w);
      chk(cur_level == 4'(8 - w), "R5 level", cur_level, 8 - w);
      cpu_iret = 1;
      @(negedge clk); cpu_iret = 0;
      chk(dev_ack == 0 && vec_valid == 0, "R4 pulse width", dev_ack, 0);
      chk(cur_level == 4'(lvl), "R6 pop", cur_level, lvl);
    end else begin
      chk(vec_valid == 0 && dev_ack == 0, "R4 ignored inta", dev_ack, 0);
      chk(cur_level == 4'(lvl), "R4 level kept", cur_level, lvl);
    end
  endtask

  task automatic accept_one(input logic [7:0] p, input int exp_lvl, input string rq);
    @(negedge clk); dev_req = p; cpu_inta = 1;
    @(negedge clk); cpu_inta = 0; dev_req = '0;
    chk(cur_level == 4'(exp_lvl), rq, cur_level, exp_lvl);
  endtask

  task automatic do_pop(input int exp_lvl, input string rq);
    @(negedge clk); cpu_iret = 1;
    @(negedge clk); cpu_iret = 0;
    chk(cur_level == 4'(exp_lvl), rq, cur_level, exp_lvl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    chk(cur_level == 0, "R9 level", cur_level, 0);
    chk(vec_valid == 0 && dev_ack == 0, "R9 outputs", dev_ack, 0);
    dev_req = 8'hFF; #1;
    chk(cpu_irq == 0, "R9 enable cleared", cpu_irq, 0);
    dev_req = '0;

    // R7: base write, enable on
    cfg(1, 8'h40);
    for (int lvl = 0; lvl <= 8; lvl++) begin
      cfg(0, 8'h80 | 8'(lvl));
      chk(cur_level == 4'(lvl), "R7 level write", cur_level, lvl);
      for (int p = 0; p < 256; p++) run_pat(8'(p), lvl, 32'h40);
    end

    // R7: vector wraps modulo 256
    cfg(1, 8'hF0);
    cfg(0, 8'h80);
    run_pat(8'h80, 0, 32'hF0);

    // R1: enable bit cleared masks the line
    cfg(0, 8'h00);
    @(negedge clk); dev_req = 8'h01; #1;
    chk(cpu_irq == 0, "R1 disabled", cpu_irq, 1'b0);
    dev_req = '0;

    // R6: pop on empty stack keeps written level
    cfg(0, 8'h83);
    do_pop(3, "R6 empty pop");

    // R8, R10: nesting to full depth
    cfg(0, 8'h80);
    accept_one(8'h80, 1, "R5 nest1");
    accept_one(8'h40, 2, "R5 nest2");
    accept_one(8'h20, 3, "R5 nest3");
    accept_one(8'h10, 4, "R5 nest4");
    @(negedge clk); dev_req = 8'h01; #1;
    chk(cpu_irq == 0, "R8 full masks", cpu_irq, 0);
    cpu_iret = 1;
    @(negedge clk); cpu_iret = 0; #1;
    chk(cur_level == 3, "R8 pop level", cur_level, 3);
    chk(cpu_irq == 1, "R8 irq after pop", cpu_irq, 1);
    cpu_inta = 1; cpu_iret = 1;
    @(negedge clk); cpu_inta = 0; cpu_iret = 0; dev_req = '0;
    chk(cur_level == 8, "R10 accept wins", cur_level, 8);
    do_pop(3, "R6 pop order");
    do_pop(2, "R6 pop order");
    do_pop(1, "R6 pop order");
    do_pop(0, "R6 pop order");
    do_pop(0, "R6 empty pop");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule